// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a 16-bit up-counter with an 8-bit prescaler in front of it. It can count peripheral clock cycles or edges of an external capture pin. The current count is compared against a small bank of match values. Each match channel can set an interrupt flag, return the count to zero, or halt the counter and drop its run bit. A capture path copies the count into a read-only register on selected edges of the same pin, and it can flag each load.

Software controls the block through a flat word-addressed register port. Reads are combinational from `addr`. A write takes effect on the rising clock edge where `wr_en` is high. The `irq` output is the OR of all raw status flags.

Top module: `tmr_match_top`

## Requirements
- R1: After reset, every readable register reads zero: control (addr 0), mode (1), count (2), prescale (3), prescale counter (4), match actions (5), capture control (6), capture value (7), status (8) and the match values (16 + channel).
- R2: While the run bit (control bit 0) is 0, neither the count nor the prescale counter changes.
- R3: Writing control bit 1 (clear) zeroes the count and the prescale counter at that write edge, and they stay zero for as long as the bit remains set.
- R4: Each qualified tick moves the prescale counter forward. When the counter has reached the prescale value, it returns to 0 and the count advances by one. After T ticks from zero, with no match actions, the count reads T/(P+1) and the prescale counter reads T mod (P+1).
- R5: Mode 0 gives a tick on every clock. Modes 1, 2 and 3 give a tick on rising, falling, or both edges of `cap_in`, seen after a two-flop synchronizer.
- R6: A match occurs when the count equals match value i (addr 16+i) on a cycle where the count would advance. A match on channel i with its interrupt bit (addr 5, bit 3i) set raises status bit i.
- R7: A match on channel i with its reset bit (addr 5, bit 3i+1) set loads 0 instead of the next count, so the count cycles through 0..M.
- R8: A match on channel i with its stop bit (addr 5, bit 3i+2) set leaves the count at the match value and clears the run bit.
- R9: With capture enabled (addr 6, bit 3), a synchronized rising edge of `cap_in` loads the count into the capture value (addr 7) if bit 0 is set. A falling edge does the same if bit 1 is set. Edges of a type that is not enabled, and all edges while bit 3 is 0, leave the capture value unchanged.
- R10: A capture load raises status bit 4 only when capture interrupt (addr 6, bit 2) is set.
- R11: Writing 1s to the clear register (addr 9) drops the matching status bits. A 0 leaves a bit unchanged. A flag that is set in the same cycle as its clear stays set. `irq` is high whenever any status bit is set.
- R12: When a reset match and a stop match happen in the same cycle, the count becomes 0 and the run bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| cap_in | input | 1 | External capture / count pin, asynchronous |
| irq | output | 1 | OR of all raw status flags |

## Verification
The checker assumes that software never writes the count or the control register in the same cycle as a hardware event it judges. Its hold, clear and stop properties therefore exclude cycles that carry such a write. The stimulus keeps to this by stopping the counter before it rewrites the count or clears flags. The one exception is the set-versus-clear race, which is staged on purpose with a match that fires every tick. `cap_in` is moved only on negative clock edges and held for at least three cycles, so every edge survives the synchronizer and the count per edge is exact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // register word addresses; match value i sits at MATCH_BASE + i
    localparam logic [4:0] A_CTRL   = 5'd0;
    localparam logic [4:0] A_MODE   = 5'd1;
    localparam logic [4:0] A_COUNT  = 5'd2;
    localparam logic [4:0] A_PRE    = 5'd3;
    localparam logic [4:0] A_PCNT   = 5'd4;
    localparam logic [4:0] A_MACT   = 5'd5;
    localparam logic [4:0] A_CAPCTL = 5'd6;
    localparam logic [4:0] A_CAPV   = 5'd7;
    localparam logic [4:0] A_STAT   = 5'd8;
    localparam logic [4:0] A_CLEAR  = 5'd9;
    localparam logic [4:0] A_MATCH0 = 5'd16;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } src_e;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int SW = SYNC + 1;

    logic [SW-1:0] s_d, s_q;

    always_comb begin
        s_d = {s_q[SW-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // the last synchronizer stage is compared with one extra history flop
    assign rise = s_q[SYNC-1] & ~s_q[SYNC];
    assign fall = ~s_q[SYNC-1] & s_q[SYNC];
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic [CW-1:0]     count,
    input  logic [NCH*CW-1:0] mval,
    input  logic [3*NCH-1:0]  act,
    input  logic              advance,
    output logic [NCH-1:0]    irq_set,
    output logic              rst_hit,
    output logic              stop_hit
);
    logic [NCH-1:0] evt, rst_v, stop_v;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign evt[g]     = advance && (count == mval[g*CW +: CW]);
        assign irq_set[g] = evt[g] & act[3*g];
        assign rst_v[g]   = evt[g] & act[3*g+1];
        assign stop_v[g]  = evt[g] & act[3*g+2];
    end

    assign rst_hit  = |rst_v;
    assign stop_hit = |stop_v;
endmodule

// File: rtl/tmr_match_top.sv
module tmr_match_top
    import tmr_pkg::*;
#(
    parameter int NCH = 4,   // 3*NCH and NCH+1 must fit in CW
    parameter int CW  = 16,
    parameter int PW  = 8,
    parameter int AW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] rd_data,
    input  logic          cap_in,
    output logic          irq
);
    localparam int AB = 3 * NCH;
    localparam int SB = NCH + 1;

    typedef struct packed {
        logic              run;
        logic              clr;
        logic [1:0]        mode;
        logic [CW-1:0]     count;
        logic [PW-1:0]     pre;
        logic [PW-1:0]     pc;
        logic [AB-1:0]     act;
        logic [3:0]        capctl;
        logic [CW-1:0]     capv;
        logic [SB-1:0]     flags;
        logic [NCH*CW-1:0] mval;
    } st_t;

    st_t q, d;

    logic           c_rise, c_fall;
    logic [NCH-1:0] m_irq;
    logic           m_rst, m_stop;
    logic           tick, step, wrap, advance;
    logic           cap_evt, cap_set, clr_now;

    tmr_edge_sync #(.SYNC(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_in),
        .rise (c_rise),
        .fall (c_fall)
    );

    tmr_match_bank #(.NCH(NCH), .CW(CW)) u_bank (
        .count   (q.count),
        .mval    (q.mval),
        .act     (q.act),
        .advance (advance),
        .irq_set (m_irq),
        .rst_hit (m_rst),
        .stop_hit(m_stop)
    );

    always_comb begin
        unique case (src_e'(q.mode))
            SRC_CLK:  tick = 1'b1;
            SRC_RISE: tick = c_rise;
            SRC_FALL: tick = c_fall;
            default:  tick = c_rise | c_fall;
        endcase
        clr_now = q.clr | (wr_en && addr == A_CTRL && wr_data[1]);
        step    = q.run & tick & ~q.clr;
        wrap    = q.pc >= q.pre;
        advance = step & wrap;
        cap_evt = q.capctl[3] & ((q.capctl[0] & c_rise) | (q.capctl[1] & c_fall));
        cap_set = cap_evt & q.capctl[2];
    end

    always_comb begin
        d = q;
        // hardware progress
        if (step) d.pc = wrap ? '0 : q.pc + PW'(1);
        if (advance) begin
            if (m_rst)        d.count = '0;
            else if (!m_stop) d.count = q.count + CW'(1);
            if (m_stop)       d.run = 1'b0;
        end
        if (cap_evt) d.capv = q.count;
        if (wr_en && addr == A_CLEAR) d.flags = q.flags & ~wr_data[SB-1:0];
        d.flags = d.flags | {cap_set, m_irq};
        if (clr_now) begin
            d.count = '0;
            d.pc    = '0;
        end
        // software writes override hardware on the written field
        if (wr_en) begin
            unique case (addr)
                A_CTRL:   begin d.run = wr_data[0]; d.clr = wr_data[1]; end
                A_MODE:   d.mode   = wr_data[1:0];
                A_COUNT:  d.count  = wr_data;
                A_PRE:    d.pre    = wr_data[PW-1:0];
                A_MACT:   d.act    = wr_data[AB-1:0];
                A_CAPCTL: d.capctl = wr_data[3:0];
                default:  ;
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (addr == A_MATCH0 + AW'(i)) d.mval[i*CW +: CW] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_CTRL:   rd_data[1:0]    = {q.clr, q.run};
            A_MODE:   rd_data[1:0]    = q.mode;
            A_COUNT:  rd_data         = q.count;
            A_PRE:    rd_data[PW-1:0] = q.pre;
            A_PCNT:   rd_data[PW-1:0] = q.pc;
            A_MACT:   rd_data[AB-1:0] = q.act;
            A_CAPCTL: rd_data[3:0]    = q.capctl;
            A_CAPV:   rd_data         = q.capv;
            A_STAT:   rd_data[SB-1:0] = q.flags;
            default:  ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (addr == A_MATCH0 + AW'(i)) rd_data = q.mval[i*CW +: CW];
        end
    end

    assign irq = |q.flags;
endmodule

// File: rtl/tmr_match_chk.sv
module tmr_match_chk
    import tmr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int PW  = 8,
    parameter int AW  = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  addr,
    input logic [NCH:0]   clr_bits,
    input logic           run_q,
    input logic           clr_q,
    input logic [CW-1:0]  count_q,
    input logic [PW-1:0]  pc_q,
    input logic [NCH:0]   flags_q,
    input logic [CW-1:0]  capv_q,
    input logic [NCH-1:0] m_irq,
    input logic           m_stop,
    input logic           cap_evt,
    input logic           cap_set
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !clr_q && !(wr_en && (addr == A_COUNT || addr == A_CTRL)))
        |=> ($stable(count_q) && $stable(pc_q)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q && !(wr_en && addr == A_COUNT)) |=> (count_q == '0 && pc_q == '0));

    p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_irq != '0) |=> ((flags_q[NCH-1:0] & $past(m_irq)) == $past(m_irq)));

    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_stop && !(wr_en && addr == A_CTRL)) |=> !run_q);

    p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (capv_q == $past(count_q)));

    p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CLEAR && m_irq == '0 && !cap_set)
        |=> ((flags_q & $past(clr_bits)) == '0));
endmodule

bind tmr_match_top tmr_match_chk #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .clr_bits(wr_data[NCH:0]),
    .run_q   (q.run),
    .clr_q   (q.clr),
    .count_q (q.count),
    .pc_q    (q.pc),
    .flags_q (q.flags),
    .capv_q  (q.capv),
    .m_irq   (m_irq),
    .m_stop  (m_stop),
    .cap_evt (cap_evt),
    .cap_set (cap_set)
);

// File: tb/tmr_match_top_bench.sv
module tmr_match_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        cap_in = 1'b0;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_match_top u_tmr_match_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .cap_in(cap_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the following negedge
    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        addr = a; wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        addr = a; wr_en = 1'b0;
        #1 v = rd_data;
        @(negedge clk);
    endtask

    task automatic rchk(input string req, input logic [4:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic zero_counters();
        wr(5'd0, 16'h0002);
        wr(5'd0, 16'h0000);
    endtask

    task automatic toggle_cap(input int n);
        for (int e = 0; e < n; e++) begin
            cap_in = ~cap_in;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rchk("R1 ctrl", 5'd0, 16'h0);
        rchk("R1 count", 5'd2, 16'h0);
        rchk("R1 pre", 5'd3, 16'h0);
        rchk("R1 pcnt", 5'd4, 16'h0);
        rchk("R1 mact", 5'd5, 16'h0);
        rchk("R1 capv", 5'd7, 16'h0);
        rchk("R1 status", 5'd8, 16'h0);
        rchk("R1 match3", 5'd19, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);

        // R4 prescale sweep in clock mode: T = K + 1 ticks
        for (int p = 0; p < 4; p++) begin
            for (int k = 5; k <= 13; k += 4) begin
                zero_counters();
                wr(5'd3, 16'(p));
                wr(5'd0, 16'h0001);
                repeat (k) @(negedge clk);
                wr(5'd0, 16'h0000);
                rchk("R4 count", 5'd2, 16'((k + 1) / (p + 1)));
                rchk("R4 pcnt", 5'd4, 16'((k + 1) % (p + 1)));
            end
        end

        // R2 hold while stopped
        rd(5'd2, v);
        repeat (6) @(negedge clk);
        rd(5'd2, v2);
        chk("R2 count stable", v2, v);
        rchk("R2 pcnt stable", 5'd4, 16'((13 + 1) % 4));

        // R3 clear
        wr(5'd0, 16'h0002);
        rchk("R3 count zero", 5'd2, 16'h0);
        rchk("R3 pcnt zero", 5'd4, 16'h0);
        wr(5'd0, 16'h0000);

        // R5 edge-count modes: 6 toggles = 3 rises + 3 falls
        for (int c = 0; c < 4; c++) begin
            int m, p, e;
            m = (c == 3) ? 3 : c + 1;
            p = (c == 3) ? 1 : 0;
            e = (m == 3) ? 6 / (p + 1) : 3;
            zero_counters();
            wr(5'd3, 16'(p));
            wr(5'd1, 16'(m));
            wr(5'd0, 16'h0001);
            toggle_cap(6);
            repeat (4) @(negedge clk);
            wr(5'd0, 16'h0000);
            rchk("R5 edge count", 5'd2, 16'(e));
        end
        wr(5'd1, 16'h0000);

        // R7/R6 reset+irq on channel 0 at 5, prescale 0: count = T mod 6
        wr(5'd16, 16'd5);
        wr(5'd5, 16'h0003);
        wr(5'd3, 16'h0000);
        zero_counters();
        wr(5'd0, 16'h0001);
        repeat (20) @(negedge clk);
        wr(5'd0, 16'h0000);
        rchk("R7 wrap count", 5'd2, 16'(21 % 6));
        rchk("R6 flag set", 5'd8, 16'h0001);
        chk("R11 irq high", {15'd0, irq}, 16'h1);

        // R7 with prescale 2: count = (T/3) mod 6
        wr(5'd3, 16'h0002);
        zero_counters();
        wr(5'd0, 16'h0001);
        repeat (40) @(negedge clk);
        wr(5'd0, 16'h0000);
        rchk("R7 prescaled wrap", 5'd2, 16'((41 / 3) % 6));
        rchk("R4 prescaled pcnt", 5'd4, 16'(41 % 3));

        // R11 write-one-to-clear
        wr(5'd9, 16'h0000);
        rchk("R11 zero write keeps", 5'd8, 16'h0001);
        wr(5'd9, 16'h0001);
        rchk("R11 one write clears", 5'd8, 16'h0000);
        chk("R11 irq low", {15'd0, irq}, 16'h0);

        // R8 stop on channel 1 at 7, no irq
        wr(5'd3, 16'h0000);
        wr(5'd17, 16'd7);
        wr(5'd5, 16'h0020);
        zero_counters();
        wr(5'd0, 16'h0001);
        repeat (20) @(negedge clk);
        rchk("R8 count held", 5'd2, 16'd7);
        rchk("R8 run cleared", 5'd0, 16'h0);
        rchk("R6 no irq when disabled", 5'd8, 16'h0);

        // R12 reset and stop at the same value
        wr(5'd18, 16'd3);
        wr(5'd19, 16'd3);
        wr(5'd5, 16'h0880);
        zero_counters();
        wr(5'd0, 16'h0001);
        repeat (10) @(negedge clk);
        rchk("R12 count zero", 5'd2, 16'h0);
        rchk("R12 run cleared", 5'd0, 16'h0);

        // R11 set wins over clear: match at 0 with reset fires every tick
        wr(5'd16, 16'd0);
        wr(5'd5, 16'h0003);
        zero_counters();
        wr(5'd0, 16'h0001);
        repeat (3) @(negedge clk);
        wr(5'd9, 16'h0001);
        rchk("R11 set wins", 5'd8, 16'h0001);
        wr(5'd0, 16'h0000);
        wr(5'd9, 16'h0001);
        rchk("R11 clear after stop", 5'd8, 16'h0000);

        // R9/R10 capture with counter stopped
        wr(5'd5, 16'h0000);
        wr(5'd2, 16'h1234);
        wr(5'd6, 16'h000D);
        toggle_cap(1);
        repeat (3) @(negedge clk);
        rchk("R9 rise capture", 5'd7, 16'h1234);
        rchk("R10 capture flag", 5'd8, 16'h0010);
        wr(5'd2, 16'h2222);
        toggle_cap(1);
        repeat (3) @(negedge clk);
        rchk("R9 fall ignored", 5'd7, 16'h1234);
        wr(5'd9, 16'h0010);
        wr(5'd6, 16'h000A);
        toggle_cap(1);
        repeat (3) @(negedge clk);
        rchk("R9 rise ignored", 5'd7, 16'h1234);
        wr(5'd2, 16'h3333);
        toggle_cap(1);
        repeat (3) @(negedge clk);
        rchk("R9 fall capture", 5'd7, 16'h3333);
        rchk("R10 no flag without enable", 5'd8, 16'h0000);
        wr(5'd6, 16'h0003);
        wr(5'd2, 16'h4444);
        toggle_cap(2);
        repeat (3) @(negedge clk);
        rchk("R9 capture disabled", 5'd7, 16'h3333);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule